// File: doc/BRIEF.md
# Double-Buffered DAC Command Decoder

This block sits behind a serial receiver that assembles 24-bit command words. Each word arrives with a one-cycle valid strobe. The top byte is the command and the low sixteen bits are the payload. The decoder holds two code registers. A staging register receives written data. An output register drives the converter code. Commands can move data into the staging register alone, push it into both registers at once, or copy staging to output on request. Separate commands set power-down, the READY-output enable and a linearity-optimize flag.

An active-low load pin gives a hardware path for the same copy. A single low cycle transfers the staging code to the output. While the pin stays low, the output register follows the staging register, so every write lands on the output at the same edge. A software clear returns every register to its reset value. The reset code is zero or half scale, chosen by the `midscale_sel` pin.

A parameter selects 16-bit or 12-bit resolution. In 12-bit mode the code is kept left-justified in the 16-bit field, and the four low payload bits are stored as zero. The reset input is asynchronous, and its release is synchronised inside the block, so state appears two clocks after `rst_n` rises.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After reset, both code registers hold 16'h8000 if `midscale_sel` is high and 16'h0000 if it is low. `pwr_down` is 0, `ready_en` is 1 and `lin_opt` is 0.
- R2: A command byte whose bits [7:4] are 4'b0001 and whose bit 0 is 1 stores the payload in the staging register only, and `dac_code` is unchanged. With bit 0 at 0 the command does nothing.
- R3: A command byte whose bits [7:4] are 4'b0011 and whose bit 0 is 1 stores the payload in both registers, and it appears on `dac_code` after the accepting edge. With bit 0 at 0 the command does nothing.
- R4: Command byte 8'h01 with payload bit 8 set copies the staging register to `dac_code`. With payload bit 8 clear it changes nothing.
- R5: Command byte 8'h02 restores every register and flag to its R1 value, using `midscale_sel` as sampled at that edge. It overrides a low `ldac_n`.
- R6: Command byte 8'h03 sets `pwr_down` to payload bit 8 (a 0 powers back up) and `ready_en` to payload bit 7. `dac_code` is retained, and commands are still executed while powered down.
- R7: Command byte 8'h05 sets `lin_opt` to payload bit 9.
- R8: A single cycle with `ldac_n` low copies the staging register to `dac_code`.
- R9: While `ldac_n` is held low, a write as in R2 updates `dac_code` at the same edge as the staging register.
- R10: Command bytes 8'h00 and 8'h20, and every byte not named in R2 to R7, change no register.
- R11: With RES_BITS = 12, payload bits [3:0] are stored as zero in both registers.
- R12: A word presented while `cmd_valid` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 24 | Command byte [23:16] and payload [15:0] |
| ldac_n | input | 1 | Active-low load pin (synchronous to clk) |
| midscale_sel | input | 1 | Reset code select: 1 gives half scale, 0 gives zero |
| dac_code | output | 16 | Output register code, left-justified |
| pwr_down | output | 1 | Converter powered down |
| ready_en | output | 1 | READY output enabled |
| lin_opt | output | 1 | Linearity-optimize flag |

## Verification
The bench checks that a plain write leaves the output alone until a software load or an LDAC pulse. A design that merged the two buffers would move the output early. It sends load and write commands whose select bit is clear, and some whose don't-care bits are set. A decoder that ignored the select bit, or compared whole bytes, would act on the wrong words. It holds LDAC low across writes, and it clears while LDAC is low. This catches a transparent path that lags by a cycle and a clear that loses to LDAC. It runs a 12-bit instance in parallel and checks for low bits that leak through, and for power-down that disturbs the retained code.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int unsigned WORD_W = 24;
  localparam int unsigned CODE_W = 16;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_LOAD,
    OP_CLEAR,
    OP_POWER,
    OP_LIN,
    OP_WRITE,
    OP_WTHRU
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [CODE_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int unsigned RES_BITS = 16
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);

  localparam int unsigned DROP = CODE_W - RES_BITS;
  localparam logic [CODE_W-1:0] KEEP = {CODE_W{1'b1}} << DROP;

  logic [7:0]        ctrl;
  logic [CODE_W-1:0] pay;

  assign ctrl = word[WORD_W-1 -: 8];
  assign pay  = word[CODE_W-1:0];

  always_comb begin
    cmd.data = pay & KEEP;
    cmd.op   = OP_NOP;
    if (valid) begin
      unique case (ctrl[7:4])
        4'b0000: begin
          case (ctrl[3:0])
            4'h1:    cmd.op = pay[8] ? OP_LOAD : OP_NOP;
            4'h2:    cmd.op = OP_CLEAR;
            4'h3:    cmd.op = OP_POWER;
            4'h5:    cmd.op = OP_LIN;
            default: cmd.op = OP_NOP;
          endcase
        end
        4'b0001: cmd.op = ctrl[0] ? OP_WRITE : OP_NOP;
        4'b0011: cmd.op = ctrl[0] ? OP_WTHRU : OP_NOP;
        default: cmd.op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic              ldac_n,
  input  logic              midscale_sel,
  output logic [CODE_W-1:0] in_code,
  output logic [CODE_W-1:0] dac_code
);

  localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] rst_val;
  logic [CODE_W-1:0] in_q, in_nxt, dac_q, dac_nxt;
  logic              in_en, dac_en;

  assign rst_val = midscale_sel ? HALF : '0;

  always_comb begin
    in_en  = 1'b0;
    in_nxt = in_q;
    if (cmd.op == OP_CLEAR) begin
      in_en  = 1'b1;
      in_nxt = rst_val;
    end else if (cmd.op == OP_WRITE || cmd.op == OP_WTHRU) begin
      in_en  = 1'b1;
      in_nxt = cmd.data;
    end
  end

  always_comb begin
    dac_en  = 1'b1;
    dac_nxt = dac_q;
    if (cmd.op == OP_CLEAR)      dac_nxt = rst_val;
    else if (cmd.op == OP_WTHRU) dac_nxt = cmd.data;
    else if (!ldac_n)            dac_nxt = in_nxt;
    else if (cmd.op == OP_LOAD)  dac_nxt = in_q;
    else                         dac_en  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= rst_val;
      dac_q <= rst_val;
    end else begin
      if (in_en)  in_q  <= in_nxt;
      if (dac_en) dac_q <= dac_nxt;
    end
  end

  assign in_code  = in_q;
  assign dac_code = dac_q;

  a_r2_write_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.op == OP_WRITE && ldac_n) |=> $stable(dac_q));

  a_r3_writethrough_both: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.op == OP_WTHRU) |=> (dac_q == in_q) && (dac_q == $past(cmd.data)));

  a_r8_ldac_transfers: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n && cmd.op != OP_CLEAR) |=> (dac_q == in_q));

  a_r6_power_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.op == OP_POWER && ldac_n) |=> $stable(dac_q));

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  output logic pwr_down,
  output logic ready_en,
  output logic lin_opt
);

  logic pd_q, pd_nxt, rdy_q, rdy_nxt, lin_q, lin_nxt;
  logic flags_en;

  always_comb begin
    flags_en = 1'b1;
    pd_nxt   = pd_q;
    rdy_nxt  = rdy_q;
    lin_nxt  = lin_q;
    unique case (cmd.op)
      OP_CLEAR: begin
        pd_nxt  = 1'b0;
        rdy_nxt = 1'b1;
        lin_nxt = 1'b0;
      end
      OP_POWER: begin
        pd_nxt  = cmd.data[8];
        rdy_nxt = cmd.data[7];
      end
      OP_LIN:   lin_nxt = cmd.data[9];
      default:  flags_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      rdy_q <= 1'b1;
      lin_q <= 1'b0;
    end else if (flags_en) begin
      pd_q  <= pd_nxt;
      rdy_q <= rdy_nxt;
      lin_q <= lin_nxt;
    end
  end

  assign pwr_down = pd_q;
  assign ready_en = rdy_q;
  assign lin_opt  = lin_q;

  a_r7_lin_follows_bit9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.op == OP_LIN) |=> (lin_q == $past(cmd.data[9])));

  a_r6_power_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.op == OP_POWER) |=> (pd_q == $past(cmd.data[8])) && (rdy_q == $past(cmd.data[7])));

  a_r5_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.op == OP_CLEAR) |=> (!pd_q && rdy_q && !lin_q));

endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int unsigned RES_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [23:0] cmd_word,
  input  logic        ldac_n,
  input  logic        midscale_sel,
  output logic [15:0] dac_code,
  output logic        pwr_down,
  output logic        ready_en,
  output logic        lin_opt
);

  logic rst_meta, rst_sync_n;
  cmd_t cmd;
  logic [CODE_W-1:0] in_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dac_cmd_decode #(.RES_BITS(RES_BITS)) u_decode (
    .valid (cmd_valid),
    .word  (cmd_word),
    .cmd   (cmd)
  );

  dac_code_regs u_code (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd          (cmd),
    .ldac_n       (ldac_n),
    .midscale_sel (midscale_sel),
    .in_code      (in_code),
    .dac_code     (dac_code)
  );

  dac_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd      (cmd),
    .pwr_down (pwr_down),
    .ready_en (ready_en),
    .lin_opt  (lin_opt)
  );

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cmd_valid && ldac_n) |=> $stable(dac_code) && $stable(in_code) && $stable(lin_opt));

  a_r11_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (RES_BITS == 12) |-> (dac_code[3:0] == 4'h0 && in_code[3:0] == 4'h0));

endmodule

// File: tb/dac_cmd_decoder_bench.sv
module dac_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [23:0] cmd_word;
  logic        ldac_n;
  logic        midscale_sel;
  logic [15:0] dac_code, dac_code12;
  logic        pwr_down, ready_en, lin_opt;
  logic        pd12, rdy12, lin12;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;

  always #10 clk = ~clk;

  dac_cmd_decoder #(.RES_BITS(16)) u_dac_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ldac_n(ldac_n), .midscale_sel(midscale_sel), .dac_code(dac_code),
    .pwr_down(pwr_down), .ready_en(ready_en), .lin_opt(lin_opt)
  );

  dac_cmd_decoder #(.RES_BITS(12)) u_dac_cmd_decoder_12b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ldac_n(ldac_n), .midscale_sel(midscale_sel), .dac_code(dac_code12),
    .pwr_down(pd12), .ready_en(rdy12), .lin_opt(lin12)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // both widths: the 12-bit copy must equal the 16-bit code with low nibble cleared
  task automatic chk_code(input string tag, input logic [15:0] exp);
    chk({tag, " code16"}, dac_code, exp);
    chk({tag, " code12 (R11)"}, dac_code12, exp & 16'hFFF0);
  endtask

  task automatic chk_flags(input string tag, input logic pd, input logic rdy, input logic lin);
    chk({tag, " flags16"}, {13'd0, pwr_down, ready_en, lin_opt}, {13'd0, pd, rdy, lin});
    chk({tag, " flags12"}, {13'd0, pd12, rdy12, lin12}, {13'd0, pd, rdy, lin});
  endtask

  task automatic send(input logic [7:0] c, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {c, d};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = 24'h0;
  endtask

  task automatic pulse_ldac();
    @(negedge clk);
    ldac_n = 1'b0;
    @(negedge clk);
    ldac_n = 1'b1;
  endtask

  task automatic do_reset(input logic mid);
    @(negedge clk);
    midscale_sel = mid;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk_code("R1 midscale reset", 16'h8000);
    chk_flags("R1 reset flags", 1'b0, 1'b1, 1'b0);
    do_reset(1'b0);
    chk_code("R1 zero reset", 16'h0000);
  endtask

  task automatic t_write();
    send(8'h11, 16'hABCD);
    chk_code("R2 write holds output", 16'h0000);
    pulse_ldac();
    chk_code("R8 ldac pulse copies", 16'hABCD);
    send(8'h10, 16'h5555);
    send(8'h01, 16'h0100);
    chk_code("R2 write with select clear ignored", 16'hABCD);
  endtask

  task automatic t_load();
    send(8'h11, 16'h1357);
    send(8'h01, 16'hFEFF);
    chk_code("R4 load with bit8 clear", 16'hABCD);
    send(8'h01, 16'h0100);
    chk_code("R4 load with bit8 set", 16'h1357);
  endtask

  task automatic t_wthru();
    send(8'h31, 16'h2468);
    chk_code("R3 writethrough", 16'h2468);
    send(8'h30, 16'h9999);
    chk_code("R3 writethrough select clear", 16'h2468);
    send(8'h37, 16'h0F0F);
    chk_code("R3 writethrough dont-care bits", 16'h0F0F);
  endtask

  task automatic t_power();
    send(8'h03, 16'h0100);
    chk_flags("R6 power down", 1'b1, 1'b0, 1'b0);
    chk_code("R6 code retained", 16'h0F0F);
    send(8'h31, 16'h4444);
    chk_code("R6 active while down", 16'h4444);
    send(8'h03, 16'h0080);
    chk_flags("R6 power up", 1'b0, 1'b1, 1'b0);
    chk_code("R6 code after power up", 16'h4444);
  endtask

  task automatic t_lin();
    send(8'h05, 16'h0200);
    chk_flags("R7 lin set", 1'b0, 1'b1, 1'b1);
    send(8'h05, 16'hFDFF);
    chk_flags("R7 lin clear", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_nop();
    send(8'h00, 16'hFFFF);
    send(8'h20, 16'hFFFF);
    send(8'h07, 16'hFFFF);
    send(8'h41, 16'hFFFF);
    send(8'h81, 16'hFFFF);
    chk_code("R10 nops keep output", 16'h4444);
    chk_flags("R10 nops keep flags", 1'b0, 1'b1, 1'b0);
    pulse_ldac();
    chk_code("R10 nops keep staging", 16'h4444);
  endtask

  task automatic t_invalid();
    @(negedge clk);
    cmd_word = {8'h31, 16'h7777};
    @(negedge clk);
    cmd_word = {8'h02, 16'h0000};
    @(negedge clk);
    cmd_word = 24'h0;
    chk_code("R12 word without valid ignored", 16'h4444);
  endtask

  task automatic t_ldac_held();
    @(negedge clk);
    ldac_n = 1'b0;
    send(8'h11, 16'h6543);
    chk_code("R9 transparent write", 16'h6543);
    send(8'h11, 16'h111F);
    chk_code("R9 second transparent write", 16'h111F);
    @(negedge clk);
    ldac_n = 1'b1;
  endtask

  task automatic t_clear();
    send(8'h03, 16'h0100);
    send(8'h05, 16'h0200);
    send(8'h11, 16'h2222);
    @(negedge clk);
    midscale_sel = 1'b1;
    ldac_n = 1'b0;
    send(8'h02, 16'h0000);
    chk_code("R5 clear beats ldac", 16'h8000);
    @(negedge clk);
    ldac_n = 1'b1;
    chk_flags("R5 clear flags", 1'b0, 1'b1, 1'b0);
    pulse_ldac();
    chk_code("R5 staging cleared", 16'h8000);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_word = 24'h0;
    ldac_n = 1'b1;
    midscale_sel = 1'b0;
    t_reset();
    t_write();
    t_load();
    t_wthru();
    t_power();
    t_lin();
    t_nop();
    t_invalid();
    t_ldac_held();
    t_clear();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule